// File: doc/BRIEF.md
# Block Copy and Block Compare Sequencer

This block carries out one byte-block operation per start pulse, using three 16-bit working registers: a source pointer (HL), a destination pointer (DE) and a byte counter (BC). It has two kinds of operation. A copy moves a byte from the source to the destination. A compare checks the accumulator A against the byte at the source. Either kind can run as a single step or repeat automatically, and either can walk upward or downward through memory. On each iteration the block recomputes a full flag byte.

The surrounding core gives a 3-bit operation code together with A, BC, DE, HL and the current flag byte, then pulses `start`. While `busy` is high the sequencer owns a synchronous memory port. Reads on this port return their data one cycle after the request. Each iteration follows a fixed cycle schedule: a single step, or the last pass of a repeat, takes 16 cycles. A repeat pass that will be followed by another takes 21 cycles. After every pass the updated registers and flags appear on the outputs. A one-cycle `done` marks the end of the whole operation.

Top module: `bts_block_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd` and `mem_wr` are low, and `bc_out`, `de_out`, `hl_out` and `flags_out` are zero.
- R2: Operation code bits: op[0]=1 selects the decrementing direction, op[1]=1 selects compare (0 = copy), and op[2]=1 selects repeat. A copy pass reads the byte at HL and writes it to DE. It then moves both HL and DE by +1 (or by -1 when decrementing) and lowers BC by 1.
- R3: A compare pass reads the byte at HL and never writes. It moves HL by ±1, lowers BC by 1 and leaves DE untouched.
- R4: Counting the cycle after the accepting clock edge as cycle 0 of a pass, the read request (address HL) is in cycle 8 and the write (address DE, data = byte read) is in cycle 11. There is exactly one write per copied byte and none on a compare.
- R5: A single step, or the last pass of a repeat, lasts 16 cycles. A repeat pass that is followed by another lasts 21 cycles. `done` is high for exactly the one cycle after the last pass, and `busy` is low in that cycle.
- R6: A repeating copy keeps running until BC reaches zero.
- R7: A repeating compare stops after the pass where the byte equals A, or after the pass that brings BC to zero, whichever happens first.
- R8: Flag bit 2 (P/V) is 1 when the decremented BC is nonzero and 0 when it is zero. This holds for both kinds of operation.
- R9: Copy flags, with bit 7..0 = S,Z,YF,H,XF,P/V,N,C: H and N are cleared. YF is bit 1 and XF is bit 3 of (A + byte) mod 256. S, Z and C are kept.
- R10: Compare flags: S is bit 7 of A−byte, Z is set when the two are equal, H is the borrow out of bit 4, and N is set. YF is bit 1 and XF is bit 3 of (A − byte − H). C is kept.
- R11: If a pass starts with BC = 0, BC wraps to 0xFFFF and P/V reads 1.
- R12: A `start` pulse while `busy` is high has no effect. Operand inputs are sampled only when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted when idle |
| op | input | 3 | {repeat, compare, decrement} |
| a_in | input | 8 | Accumulator value |
| bc_in | input | 16 | Byte counter |
| de_in | input | 16 | Destination pointer |
| hl_in | input | 16 | Source pointer |
| flags_in | input | 8 | Flag byte before the operation |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read request, data returned next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| bc_out | output | 16 | Working byte counter |
| de_out | output | 16 | Working destination pointer |
| hl_out | output | 16 | Working source pointer |
| flags_out | output | 8 | Working flag byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
A phase counter that slips moves the read or write strobe away from cycles 8 and 11, or makes a pass end early or late. The per-cycle comparison catches this in the very cycle it happens. If the captured byte or a pointer step is wrong, the written data or address is wrong at the next write strobe, and `hl_out`, `de_out` and `flags_out` are wrong in the first cycle after that pass ends. A wrong stop decision is visible in the cycle where `done` should have risen, or where the next pass should have begun.

// File: rtl/bts_pkg.sv
package bts_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic rep;
    logic cmp;
    logic dec;
  } bts_op_t;

  localparam int FLG_S  = 7;
  localparam int FLG_Z  = 6;
  localparam int FLG_Y  = 5;
  localparam int FLG_H  = 4;
  localparam int FLG_X  = 3;
  localparam int FLG_PV = 2;
  localparam int FLG_N  = 1;
  localparam int FLG_C  = 0;
endpackage

// File: rtl/bts_phase_ctr.sv
module bts_phase_ctr #(
  parameter int STEP_LEN = 16,
  parameter int LOOP_LEN = 21,
  parameter int RD_SLOT  = 8,
  parameter int WR_SLOT  = 11,
  localparam int CW       = $clog2(LOOP_LEN + 1),
  localparam int CAP_SLOT = RD_SLOT + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic run,
  input  logic long_iter,
  output logic rd_slot,
  output logic cap_slot,
  output logic wr_slot,
  output logic iter_end
);
  logic [CW-1:0] cyc_q, cyc_d, last_c;
  logic          cnt_en;

  always_comb begin
    last_c   = long_iter ? CW'(LOOP_LEN - 1) : CW'(STEP_LEN - 1);
    iter_end = run && (cyc_q == last_c);
    rd_slot  = run && (cyc_q == CW'(RD_SLOT));
    cap_slot = run && (cyc_q == CW'(CAP_SLOT));
    wr_slot  = run && (cyc_q == CW'(WR_SLOT));
    cnt_en   = launch | run;
    if (launch || iter_end) cyc_d = '0;
    else                    cyc_d = cyc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cyc_q <= '0;
    else if (cnt_en) cyc_q <= cyc_d;
  end

  // R5
  cyc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cyc_q < CW'(LOOP_LEN)));
endmodule

// File: rtl/bts_ptr_step.sv
module bts_ptr_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         dec,
  output logic [W-1:0] nxt
);
  always_comb nxt = dec ? (val - 1'b1) : (val + 1'b1);
endmodule

// File: rtl/bts_flag_calc.sv
module bts_flag_calc
  import bts_pkg::*;
(
  input  logic              cmp,
  input  logic [BYTE_W-1:0] acc,
  input  logic [BYTE_W-1:0] data,
  input  logic              bc_nz,
  input  logic [7:0]        flg_old,
  output logic [7:0]        flg_new,
  output logic              match
);
  logic [BYTE_W-1:0] sum, diff, adj;
  logic              half;

  always_comb begin
    sum   = acc + data;
    diff  = acc - data;
    half  = acc[3:0] < data[3:0];
    adj   = diff - {{(BYTE_W-1){1'b0}}, half};
    match = (diff == '0);
    flg_new = flg_old;
    flg_new[FLG_PV] = bc_nz;
    if (cmp) begin
      flg_new[FLG_S] = diff[7];
      flg_new[FLG_Z] = match;
      flg_new[FLG_Y] = adj[1];
      flg_new[FLG_H] = half;
      flg_new[FLG_X] = adj[3];
      flg_new[FLG_N] = 1'b1;
    end else begin
      flg_new[FLG_Y] = sum[1];
      flg_new[FLG_H] = 1'b0;
      flg_new[FLG_X] = sum[3];
      flg_new[FLG_N] = 1'b0;
    end
  end
endmodule

// File: rtl/bts_block_seq.sv
module bts_block_seq
  import bts_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 16,
  parameter int STEP_LEN = 16,
  parameter int LOOP_LEN = 21,
  parameter int RD_SLOT  = 8,
  parameter int WR_SLOT  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [BYTE_W-1:0] a_in,
  input  logic [CNT_W-1:0]  bc_in,
  input  logic [ADDR_W-1:0] de_in,
  input  logic [ADDR_W-1:0] hl_in,
  input  logic [7:0]        flags_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  bc_out,
  output logic [ADDR_W-1:0] de_out,
  output logic [ADDR_W-1:0] hl_out,
  output logic [7:0]        flags_out,
  output logic              busy,
  output logic              done
);
  bts_op_t           op_q, op_d;
  logic [BYTE_W-1:0] a_q, a_d, byte_q, byte_d;
  logic [CNT_W-1:0]  bc_q, bc_d, bc_nxt;
  logic [ADDR_W-1:0] de_q, de_d, de_nxt, hl_q, hl_d, hl_nxt;
  logic [7:0]        flg_q, flg_d, flg_new;
  logic              busy_q, busy_d, done_q, done_d;
  logic              accept, more, match, bc_nz;
  logic              rd_slot, cap_slot, wr_slot, iter_end;
  logic              reg_en;

  bts_ptr_step #(.W(CNT_W))  u_bc_step (.val(bc_q), .dec(1'b1),     .nxt(bc_nxt));
  bts_ptr_step #(.W(ADDR_W)) u_hl_step (.val(hl_q), .dec(op_q.dec), .nxt(hl_nxt));
  bts_ptr_step #(.W(ADDR_W)) u_de_step (.val(de_q), .dec(op_q.dec), .nxt(de_nxt));

  bts_flag_calc u_flags (
    .cmp     (op_q.cmp),
    .acc     (a_q),
    .data    (byte_q),
    .bc_nz   (bc_nz),
    .flg_old (flg_q),
    .flg_new (flg_new),
    .match   (match)
  );

  bts_phase_ctr #(
    .STEP_LEN (STEP_LEN),
    .LOOP_LEN (LOOP_LEN),
    .RD_SLOT  (RD_SLOT),
    .WR_SLOT  (WR_SLOT)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (accept),
    .run       (busy_q),
    .long_iter (more),
    .rd_slot   (rd_slot),
    .cap_slot  (cap_slot),
    .wr_slot   (wr_slot),
    .iter_end  (iter_end)
  );

  always_comb begin
    accept = start && !busy_q;
    bc_nz  = |bc_nxt;
    more   = op_q.rep && bc_nz && !(op_q.cmp && match);
    reg_en = accept | iter_end;

    op_d   = op_q;
    a_d    = a_q;
    bc_d   = bc_q;
    de_d   = de_q;
    hl_d   = hl_q;
    flg_d  = flg_q;
    busy_d = busy_q;
    done_d = 1'b0;
    byte_d = cap_slot ? mem_rdata : byte_q;

    if (accept) begin
      op_d   = bts_op_t'(op);
      a_d    = a_in;
      bc_d   = bc_in;
      de_d   = de_in;
      hl_d   = hl_in;
      flg_d  = flags_in;
      busy_d = 1'b1;
    end else if (iter_end) begin
      bc_d  = bc_nxt;
      hl_d  = hl_nxt;
      de_d  = op_q.cmp ? de_q : de_nxt;
      flg_d = flg_new;
      if (!more) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      a_q   <= '0;
      bc_q  <= '0;
      de_q  <= '0;
      hl_q  <= '0;
      flg_q <= '0;
    end else if (reg_en) begin
      op_q  <= op_d;
      a_q   <= a_d;
      bc_q  <= bc_d;
      de_q  <= de_d;
      hl_q  <= hl_d;
      flg_q <= flg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        byte_q <= '0;
    else if (cap_slot) byte_q <= byte_d;
  end

  always_comb begin
    mem_rd    = rd_slot;
    mem_wr    = wr_slot && !op_q.cmp;
    mem_addr  = mem_wr ? de_q : hl_q;
    mem_wdata = byte_q;
    bc_out    = bc_q;
    de_out    = de_q;
    hl_out    = hl_q;
    flags_out = flg_q;
    busy      = busy_q;
    done      = done_q;
  end

  // R4
  wr_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> busy_q);
  // R4
  single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R6
  copy_rep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && op_q.rep && !op_q.cmp) |-> (bc_q == '0));
  // R7
  cmp_rep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && op_q.rep && op_q.cmp) |-> ((bc_q == '0) || flg_q[FLG_Z]));
  // R8
  pv_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (flg_q[FLG_PV] == (bc_q != '0)));
endmodule

// File: tb/tb_bts_block_seq.sv
module tb_bts_block_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, start;
  logic [2:0]  op;
  logic [7:0]  a_in, flags_in, mem_wdata, mem_rdata, flags_out;
  logic [15:0] bc_in, de_in, hl_in, mem_addr, bc_out, de_out, hl_out;
  logic        mem_rd, mem_wr, busy, done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [7:0] ram [int];
  logic [7:0] shadow [int];

  typedef struct {
    bit rd; bit wr; int addr; int wdata;
    bit busy; bit done; int bc; int de; int hl; int fl;
  } exp_t;
  exp_t q [$];

  bts_block_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a_in(a_in),
    .bc_in(bc_in), .de_in(de_in), .hl_in(hl_in), .flags_in(flags_in),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .bc_out(bc_out), .de_out(de_out), .hl_out(hl_out),
    .flags_out(flags_out), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
    if (mem_wr) ram[int'(mem_addr)] = mem_wdata;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++; checks++;
      $display("FAIL R5 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int rd_mem(input int adr);
    return shadow.exists(adr) ? int'(shadow[adr]) : 0;
  endfunction

  // Behavioural reference: builds one entry per cycle after the accepting edge.
  task automatic build_model(input int opc, input int a, input int bc,
                             input int de, input int hl, input int fl);
    bit dec = opc[0];
    bit cmp = opc[1];
    bit rep = opc[2];
    bit more = 1;
    int cbc = bc, cde = de, chl = hl, cfl = fl;
    shadow = ram;
    q.delete();
    while (more) begin
      int b   = rd_mem(chl);
      int nbc = (cbc + 65535) % 65536;
      int pv  = (nbc != 0) ? 1 : 0;
      int nfl;
      int len;
      if (cmp) begin
        int d  = (a - b + 256) % 256;
        int h  = ((a % 16) < (b % 16)) ? 1 : 0;
        int d2 = (a - b - h + 512) % 256;
        nfl = (cfl % 2) + ((d / 128) * 128) + ((d == 0) ? 64 : 0)
            + (((d2 / 2) % 2) * 32) + (h * 16) + (((d2 / 8) % 2) * 8)
            + (pv * 4) + 2;
      end else begin
        int s = (a + b) % 256;
        nfl = (cfl / 64 * 64) + (cfl % 2)
            + (((s / 2) % 2) * 32) + (((s / 8) % 2) * 8) + (pv * 4);
      end
      more = rep && (nbc != 0) && !(cmp && (b == a));
      len  = more ? 21 : 16;
      for (int k = 0; k < len; k++) begin
        exp_t e;
        e.rd = (k == 8); e.wr = (!cmp && k == 11);
        e.addr = (k == 11) ? cde : chl; e.wdata = b;
        e.busy = 1; e.done = 0;
        e.bc = cbc; e.de = cde; e.hl = chl; e.fl = cfl;
        q.push_back(e);
      end
      if (!cmp) shadow[cde] = b[7:0];
      cbc = nbc;
      chl = dec ? (chl + 65535) % 65536 : (chl + 1) % 65536;
      if (!cmp) cde = dec ? (cde + 65535) % 65536 : (cde + 1) % 65536;
      cfl = nfl;
    end
    for (int k = 0; k < 2; k++) begin
      exp_t e;
      e.rd = 0; e.wr = 0; e.addr = 0; e.wdata = 0;
      e.busy = 0; e.done = (k == 0);
      e.bc = cbc; e.de = cde; e.hl = chl; e.fl = cfl;
      q.push_back(e);
    end
  endtask

  task automatic run_op(input int opc, input int a, input int bc, input int de,
                        input int hl, input int fl, input bit poke);
    string treg = opc[1] ? "R3" : "R2";
    string tflg = opc[1] ? "R10" : "R9";
    string tend = opc[2] ? (opc[1] ? "R7" : "R6") : "R5";
    @(negedge clk);
    op = opc[2:0]; a_in = a[7:0]; bc_in = bc[15:0]; de_in = de[15:0];
    hl_in = hl[15:0]; flags_in = fl[7:0]; start = 1'b1;
    build_model(opc, a, bc, de, hl, fl);
    @(negedge clk);
    start = 1'b0;
    // R12: operands scrambled after acceptance
    op = ~op; a_in = ~a_in; bc_in = 16'h1234; de_in = ~de_in; hl_in = ~hl_in;
    flags_in = ~flags_in;
    for (int i = 0; i < q.size(); i++) begin
      exp_t e = q[i];
      chk("R4", "mem_rd", int'(mem_rd), int'(e.rd));
      chk("R4", "mem_wr", int'(mem_wr), int'(e.wr));
      if (e.rd || e.wr) chk("R4", "mem_addr", int'(mem_addr), e.addr);
      if (e.wr) chk("R2", "mem_wdata", int'(mem_wdata), e.wdata);
      chk(e.done ? tend : "R5", "busy", int'(busy), int'(e.busy));
      chk(e.done ? tend : "R5", "done", int'(done), int'(e.done));
      chk(treg, "bc_out", int'(bc_out), e.bc);
      chk(treg, "de_out", int'(de_out), e.de);
      chk(treg, "hl_out", int'(hl_out), e.hl);
      chk(tflg, "flags_out", int'(flags_out & 8'hFB), e.fl & 'hFB);
      chk("R8", "pv", int'(flags_out[2]), (e.fl / 4) % 2);
      start = poke && (i == 4 || i == 12);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op = '0; a_in = '0; bc_in = '0; de_in = '0;
    hl_in = '0; flags_in = '0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "mem_rd", int'(mem_rd), 0);
    chk("R1", "mem_wr", int'(mem_wr), 0);
    chk("R1", "regs", int'(bc_out | de_out | hl_out | 16'(flags_out)), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      ram[32'h1000 + i] = 8'(8'h30 + 8'(i * 7));
      ram[32'h3000 + i] = 8'(8'h50 + 8'(i));
    end

    // R2 R9 single copy, incrementing, S Z C kept
    run_op(3'b000, 'h12, 5, 'h2000, 'h1000, 'hC1, 0);
    // R2 single copy, decrementing
    run_op(3'b001, 'hF0, 2, 'h2100, 'h1005, 'h3E, 0);
    // R3 R10 single compare with match
    run_op(3'b010, 'h37, 9, 'h4444, 'h1001, 'h01, 0);
    // R3 R10 single compare, decrementing, half borrow
    run_op(3'b011, 'h40, 1, 'h5555, 'h3003, 'h00, 0);
    // R6 R12 repeat copy incrementing with start pokes while busy
    run_op(3'b100, 'h05, 4, 'h2200, 'h1000, 'h80, 1);
    chk("R12", "bc after pokes", int'(bc_out), 0);
    chk("R12", "de after pokes", int'(de_out), 'h2204);
    // R6 repeat copy decrementing
    run_op(3'b101, 'hAA, 3, 'h2300, 'h1008, 'h41, 0);
    // R7 repeat compare stops on match (third byte 0x52)
    run_op(3'b110, 'h52, 6, 'h0, 'h3000, 'h00, 0);
    chk("R7", "stop bc", int'(bc_out), 3);
    // R7 repeat compare, decrementing, stops on BC zero
    run_op(3'b111, 'hFF, 3, 'h0, 'h3005, 'h01, 0);
    chk("R7", "stop bc zero", int'(bc_out), 0);
    // R11 wrap of BC from zero
    run_op(3'b000, 'h00, 0, 'h2400, 'h1002, 'h00, 0);
    chk("R11", "bc wrap", int'(bc_out), 'hFFFF);
    chk("R11", "pv after wrap", int'(flags_out[2]), 1);
    // R11 compare with BC zero and decrementing pointer wrap
    run_op(3'b011, 'h10, 0, 'h0, 'h0000, 'h00, 0);
    chk("R11", "hl wrap", int'(hl_out), 'hFFFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule